// File: doc/BRIEF.md
# Asynchronous One-Time-Programmable Memory Read Controller

This block lets clocked logic fetch bytes from an external asynchronous 32K x 8 one-time-programmable memory. A requester presents a 15-bit word address on a valid/ready handshake. The controller latches that address onto the memory address bus and pulls the chip-select and output-drive strobes low. It then waits a fixed number of clock cycles that covers the slowest of the memory's access limits. At the end of the wait it samples the 8-bit data bus and returns the byte with a single-cycle response flag.

After each read both strobes return high. The controller then holds off the next request for a release gap, which lets the memory stop driving the shared bus and keeps successive address changes at least one read-cycle time apart. The write-enable strobe of the memory is tied inactive, so the part can never enter its programming mode.

The wait counts come from the clock period and the speed grade. Each count is ceil(limit / period) plus one margin cycle. The access limit is the largest of the address-, select- and output-drive-relative limits (45/45/15 ns for grade 0, 40/40/15 ns for grade 1). The release limit is 15 ns. With the defaults (4000 ps period, grade 0) the access window is 13 cycles and the release window is 5 cycles.

Top module: `otp_rd_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, mem_ce_n = 1, mem_oe_n = 1, req_ready = 1 and rsp_valid = 0. A read in progress when reset arrives is abandoned.
- R2: mem_pe_n is 1 in every cycle.
- R3: A request is taken in a cycle where req_valid = 1 and req_ready = 1. req_ready is 0 from the next cycle until the release window has finished. req_valid and req_addr have no effect while req_ready = 0.
- R4: In the cycle after acceptance mem_ce_n = 0 and mem_oe_n = 0 (read mode), and mem_addr equals the accepted address. Both strobes stay low for exactly 13 cycles at the defaults.
- R5: mem_dq is sampled at the clock edge that ends the 13-cycle access window. The byte appears on rsp_data in the following cycle, when both strobes are already high again.
- R6: After the strobes rise, req_ready stays 0 for 5 cycles at the defaults. The strobes are therefore never pulled low again within 15 ns of being released.
- R7: Each accepted request yields exactly one rsp_valid pulse of one cycle.
- R8: mem_addr does not change in any cycle in which mem_ce_n stays low.
- R9: mem_oe_n is never 0 while mem_ce_n is 1. Only standby (both high) and read (both low) are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 15 | Word address of the request |
| rsp_valid | output | 1 | One-cycle flag that rsp_data holds a result |
| rsp_data | output | 8 | Byte read from the memory |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output drive enable, active low |
| mem_pe_n | output | 1 | Memory write enable, held high |
| mem_addr | output | 15 | Memory address bus |
| mem_dq | input | 8 | Memory data bus as seen by the controller |

## Verification
The assertions assume that the clock really runs at the period given by the parameter. They also assume that reset is held for at least as long as the release window, so that a read cut short by reset does not overlap the next one. The stimulus uses a 4 ns clock that matches the default parameter, and it keeps reset high for six cycles whenever it interrupts a read. The memory model returns unknown data until every access limit has passed and flags any re-selection inside the 15 ns release time. An early sample or a rushed restart therefore shows up as a data or overlap mismatch. Request valid and address are deliberately changed while the controller is busy, to show that they are ignored.

// File: rtl/otp_rd_pkg.sv
`timescale 1ns/1ps
package otp_rd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACCESS  = 2'd1,
        PH_RELEASE = 2'd2
    } phase_t;

    localparam int RELEASE_PS = 15000;
    localparam int OE_ACC_PS  = 15000;

    // address- and select-relative access limit per speed grade
    function automatic int grade_access_ps(input int grade);
        return (grade == 1) ? 40000 : 45000;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // worst of the three access limits
    function automatic int access_ps(input int grade);
        return max2(grade_access_ps(grade), OE_ACC_PS);
    endfunction

    // minimum read cycle equals the address access limit
    function automatic int cycle_ps(input int grade);
        return grade_access_ps(grade);
    endfunction

    // ceil(limit / period) plus one margin cycle
    function automatic int wait_cycles(input int limit_ps, input int period_ps);
        return (limit_ps + period_ps - 1) / period_ps + 1;
    endfunction

endpackage

// File: rtl/otp_rd_timer.sv
`timescale 1ns/1ps
module otp_rd_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

    // R4: a loaded window starts from the requested count
    assert_timer_load_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)))
        else $error("timer did not take the load value");

endmodule

// File: rtl/otp_rd_capture.sv
`timescale 1ns/1ps
module otp_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = take;
        if (take) begin
            cap_d.data = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rsp_valid = cap_q.vld;
    assign rsp_data  = cap_q.data;

    // R7: the response flag is a single-cycle pulse
    assert_rsp_single_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid)
        else $error("response flag held for more than one cycle");

endmodule

// File: rtl/otp_rd_ctrl.sv
`timescale 1ns/1ps
module otp_rd_ctrl
    import otp_rd_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_PS = 4000,
    parameter int SPEED_GRADE   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_pe_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_dq
);
    localparam int ACC_CYC  = wait_cycles(access_ps(SPEED_GRADE), CLK_PERIOD_PS);
    localparam int RC_CYC   = wait_cycles(cycle_ps(SPEED_GRADE), CLK_PERIOD_PS);
    localparam int HOLD_CYC = max2(ACC_CYC, RC_CYC);
    localparam int REL_CYC  = wait_cycles(RELEASE_PS, CLK_PERIOD_PS);
    localparam int CNT_W    = $clog2(max2(HOLD_CYC, REL_CYC) + 1);

    typedef struct packed {
        phase_t            ph;
        logic              ce_n;
        logic              oe_n;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             cap_take;

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_take = 1'b0;
        case (seq_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    seq_d.ph   = PH_ACCESS;
                    seq_d.ce_n = 1'b0;
                    seq_d.oe_n = 1'b0;
                    seq_d.addr = req_addr;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(HOLD_CYC - 1);
                end
            end
            PH_ACCESS: begin
                if (tmr_zero) begin
                    cap_take   = 1'b1;
                    seq_d.ph   = PH_RELEASE;
                    seq_d.ce_n = 1'b1;
                    seq_d.oe_n = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(REL_CYC - 1);
                end
            end
            PH_RELEASE: begin
                if (tmr_zero) begin
                    seq_d.ph = PH_IDLE;
                end
            end
            default: begin
                seq_d.ph   = PH_IDLE;
                seq_d.ce_n = 1'b1;
                seq_d.oe_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.ph   <= PH_IDLE;
            seq_q.ce_n <= 1'b1;
            seq_q.oe_n <= 1'b1;
            seq_q.addr <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    otp_rd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    otp_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .take      (cap_take),
        .din       (mem_dq),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    assign req_ready = (seq_q.ph == PH_IDLE);
    assign mem_ce_n  = seq_q.ce_n;
    assign mem_oe_n  = seq_q.oe_n;
    assign mem_pe_n  = 1'b1;
    assign mem_addr  = seq_q.addr;

    // cycles spent with the select strobe high, saturating at the release window
    logic [CNT_W-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= CNT_W'(REL_CYC);
        end else if (!mem_ce_n) begin
            gap_q <= '0;
        end else if (gap_q < CNT_W'(REL_CYC)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R6: select is re-asserted only after a full release window
    assert_release_gap_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |-> (gap_q >= CNT_W'(REL_CYC)))
        else $error("strobes re-asserted inside the release window");

    // R8: address held while the memory is selected
    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr))
        else $error("address moved during a selected cycle");

    // R9: output drive only together with chip select
    assert_oe_with_ce_R9: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_ce_n)
        else $error("output drive enabled without chip select");

    // R3: acceptance blocks further requests
    assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready)
        else $error("ready stayed high after acceptance");

    // R5: a result is returned only after the strobes are released
    assert_rsp_in_release_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (mem_ce_n && !req_ready))
        else $error("response outside the release phase");

endmodule

// File: tb/tb_otp_rd_ctrl.sv
`timescale 1ns/1ps
module tb_otp_rd_ctrl;
    localparam int  ACC = 13;
    localparam int  REL = 5;
    localparam real T_AA = 45.0;
    localparam real T_CE = 45.0;
    localparam real T_OE = 15.0;
    localparam real T_RL = 15.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [14:0] req_addr = '0;
    logic        req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_pe_n;
    logic [7:0]  rsp_data;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq = 'z;

    int checks = 0;
    int bad = 0;
    int overlaps = 0;
    bit done = 0;

    always #2 clk = ~clk;

    otp_rd_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pe_n(mem_pe_n),
        .mem_addr(mem_addr), .mem_dq(mem_dq)
    );

    function automatic logic [7:0] content(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    // ---------------- memory model ----------------
    realtime t_addr = 0, t_ce = 0, t_oe = 0, t_off = -100;
    always @(mem_addr) t_addr = $realtime;
    always @(negedge mem_oe_n) t_oe = $realtime;
    always @(posedge mem_ce_n or posedge mem_oe_n) t_off = $realtime;
    always @(negedge mem_ce_n) begin
        t_ce = $realtime;
        if ($realtime - t_off < T_RL) overlaps++;
    end

    initial begin
        #0.25;
        forever begin
            if (mem_ce_n !== 1'b0 || mem_oe_n !== 1'b0) begin
                mem_dq = ($realtime - t_off < T_RL) ? 8'hxx : 8'hzz;
            end else if (($realtime - t_addr >= T_AA) && ($realtime - t_ce >= T_CE)
                         && ($realtime - t_oe >= T_OE)) begin
                mem_dq = content(mem_addr);
            end else begin
                mem_dq = 8'hxx;
            end
            #0.5;
        end
    end

    // ---------------- reference model ----------------
    bit          m_ready = 1, m_sel = 0, m_rv = 0;
    logic [14:0] m_addr = '0;
    logic [7:0]  m_rd = '0;
    int          acc_left = 0, rel_left = 0;

    task automatic model_step(input logic v, input logic [14:0] a, input logic r);
        m_rv = 0;
        if (r) begin
            m_ready = 1; m_sel = 0; acc_left = 0; rel_left = 0;
        end else if (m_ready && v) begin
            m_ready = 0; m_sel = 1; m_addr = a; acc_left = ACC;
        end else if (acc_left > 0) begin
            acc_left--;
            if (acc_left == 0) begin
                m_rv = 1; m_rd = content(m_addr); m_sel = 0; rel_left = REL;
            end
        end else if (rel_left > 0) begin
            rel_left--;
            if (rel_left == 0) m_ready = 1;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare();
        chk(req_ready === m_ready, "R3 req_ready", 32'(req_ready), 32'(m_ready));
        chk(mem_ce_n === !m_sel, "R4 mem_ce_n", 32'(mem_ce_n), 32'(!m_sel));
        chk(mem_oe_n === !m_sel, "R9 mem_oe_n", 32'(mem_oe_n), 32'(!m_sel));
        chk(mem_pe_n === 1'b1, "R2 mem_pe_n", 32'(mem_pe_n), 32'd1);
        if (m_sel) chk(mem_addr === m_addr, "R8 mem_addr", 32'(mem_addr), 32'(m_addr));
        chk(rsp_valid === m_rv, "R7 rsp_valid", 32'(rsp_valid), 32'(m_rv));
        if (m_rv) chk(rsp_data === m_rd, "R5 rsp_data", 32'(rsp_data), 32'(m_rd));
    endtask

    task automatic cyc(input logic v, input logic [14:0] a, input logic r);
        @(negedge clk);
        compare();
        req_valid = v; req_addr = a; rst = r;
        model_step(v, a, r);
    endtask

    task automatic check_idle(input string tag);
        @(negedge clk);
        chk(mem_ce_n === 1'b1, tag, 32'(mem_ce_n), 32'd1);
        chk(mem_oe_n === 1'b1, tag, 32'(mem_oe_n), 32'd1);
        chk(req_ready === 1'b1, tag, 32'(req_ready), 32'd1);
        chk(rsp_valid === 1'b0, tag, 32'(rsp_valid), 32'd0);
    endtask

    logic [15:0] lfsr = 16'hACE1;
    task automatic lfsr_next();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 reset state");
        model_step(1'b0, '0, 1'b1);
        rst = 1'b0;
        model_step(1'b0, '0, 1'b0);
        for (int i = 0; i < 10; i++) cyc(1'b0, '0, 1'b0);
        // boundary addresses, single reads (R4, R5)
        cyc(1'b1, 15'h0000, 1'b0);
        for (int i = 0; i < 25; i++) cyc(1'b0, 15'h7777, 1'b0);
        cyc(1'b1, 15'h7FFF, 1'b0);
        for (int i = 0; i < 25; i++) cyc(1'b0, '0, 1'b0);
        // back-to-back with address churning while busy (R3, R6, R8)
        for (int i = 0; i < 200; i++) begin
            lfsr_next();
            cyc(1'b1, lfsr[14:0], 1'b0);
        end
        // sparse requests with toggling valid (R3, R7)
        for (int i = 0; i < 400; i++) begin
            lfsr_next();
            cyc(lfsr[0] & lfsr[5], lfsr[15:1], 1'b0);
        end
        for (int i = 0; i < 25; i++) cyc(1'b0, '0, 1'b0);
        // reset in the middle of an access (R1)
        cyc(1'b1, 15'h2AAA, 1'b0);
        for (int i = 0; i < 5; i++) cyc(1'b0, '0, 1'b0);
        for (int i = 0; i < 6; i++) cyc(1'b0, '0, 1'b1);
        check_idle("R1 reset mid-access");
        model_step(1'b0, '0, 1'b0);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b0);
        cyc(1'b1, 15'h1555, 1'b0);
        for (int i = 0; i < 25; i++) cyc(1'b0, '0, 1'b0);
        chk(overlaps == 0, "R6 bus overlap", 32'(overlaps), 32'd0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule